// File: doc/BRIEF.md
# Inset overlay window and border generator

This block runs on the display clock of the main picture. It decides where a reduced inset picture lands on screen. Pixels are counted from the rising edge of horizontal sync and lines from the rising edge of vertical sync. The inset rectangle sits in one of four corners. Its position is trimmed by a coarse horizontal offset and a coarse vertical offset, and a border of selectable width, height and brightness can surround it.

For every pixel the block tells the output path what to show: inset data, border colour or black. For inset pixels it also gives read addresses for the picture store. A select strobe, delayed to match external analog wiring, marks where the overlay is visible. The picture store and the conversion to analog are outside this block.

Top module: `pip_overlay_window`

## Requirements
- R1: While reset is asserted and on leaving it, `sel` is 0, `src` is 0 (black) and all three address outputs are 0. Both counters reset to their saturated value, so nothing is drawn before the first sync edges.
- R2: The pixel index becomes 0 at the clock edge where `hs` is first sampled high after being low, and it then increases by one per clock. The line index becomes 0 at the edge where `vs` is first sampled high and increases by one at each such `hs` edge. When both rise at the same edge, `vs` wins.
- R3: `corner` bit 0 selects the right side and bit 1 selects the bottom. The outer left pixel is 54 on the left side, and 448 (third size, `quarter`=0) or 502 (quarter size) on the right. The outer top line with `interlaced`=0 is 57/41 (625/525, `std525`=0/1) at the top, 365/293 at the bottom for third size, and 409/333 at the bottom for quarter size. With `interlaced`=1 each value v becomes (v+1)/2.
- R4: The outer left pixel moves by 4*`hoff`-32 and the outer top line by 2*`voff`-16, so a value of 8 in both fields leaves the R3 positions. When `mixed` is 1, `voff` counts as 0.
- R5: The inset is 212 pixels wide at third size and 160 at quarter size. With `interlaced`=1 it is 88/76 lines tall (third, 625/525) or 66/57 (quarter). With `interlaced`=0 it is twice that.
- R6: The border is 6 pixels wide (4 when `frame_narrow`=1) on each side and 3 lines tall (2 when `frame_short`=1) above and below the inset. With `frame_on`=0 the border area shows black.
- R7: `src` codes are 0 black, 1 inset, 2 border, and 3 never occurs. `src` shows the pixel at index k at the clock edge after the counter holds k.
- R8: `sel` is 1 exactly when the `src` value from `sel_dly` clocks earlier (0..7) was not black.
- R9: With `enable`=0, `src` is black and `sel` is 0 from the next clock.
- R10: For inset pixels `luma_addr` = pixel index minus the inset's first pixel, `chroma_addr` = `luma_addr`/4, and `line_addr` = line index minus the inset's first line. All three are 0 whenever `src` is not 1.
- R11: With `lvl_en`=1, `frame_lvl` equals `lvl`. Otherwise it is 12 (bright) or 4 (dark). Hue codes 0..7 are blue, violet, green, white, red, yellow, orange and cyan. The light hues are white, yellow, orange and cyan. `dark_sel`=1 makes light hues dark and the others bright, and `dark_sel`=0 does the opposite.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Display pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hs | input | 1 | Horizontal sync, rising edge starts a line |
| vs | input | 1 | Vertical sync, rising edge starts a field |
| enable | input | 1 | Overlay on |
| corner | input | 2 | Corner select (bit0 right, bit1 bottom) |
| quarter | input | 1 | 1 = quarter size, 0 = third size |
| std525 | input | 1 | 1 = 525-line display, 0 = 625 |
| interlaced | input | 1 | Interlaced line coordinates |
| mixed | input | 1 | Mixed field-rate mode, vertical offset ignored |
| hoff | input | 6 | Horizontal offset, 4 clocks per step |
| voff | input | 4 | Vertical offset, 2 lines per step |
| frame_on | input | 1 | Draw border |
| frame_narrow | input | 1 | Border 4 pixels instead of 6 |
| frame_short | input | 1 | Border 2 lines instead of 3 |
| hue | input | 3 | Border colour code |
| dark_sel | input | 1 | Dark/bright choice per hue group |
| lvl_en | input | 1 | Use `lvl` for border brightness |
| lvl | input | 4 | Border brightness, 16 steps |
| sel_dly | input | 3 | Extra select delay in clocks |
| sel | output | 1 | Overlay visible strobe |
| src | output | 2 | Output source: 0 black, 1 inset, 2 border |
| luma_addr | output | 8 | Luma read address within the line |
| chroma_addr | output | 6 | Chroma read address within the line |
| line_addr | output | 8 | Inset line address |
| frame_lvl | output | 4 | Border brightness |

## Verification
The assertions assume that the configuration inputs hold still while the window is being drawn, and that `hs` pulses are spaced so that the inset never spans a pixel-counter reset. The luma-step property depends on both. The stimulus changes configuration only after a field restart and well away from any window. It builds the lines before the target line as two-clock hs pulses, which always fall left of the smallest possible window start (pixel 22). It then draws one full line of 910 pixels, so the widest window, which ends below pixel 895, lies wholly inside that line.

// File: rtl/pip_overlay_window.sv
module pip_overlay_window #(
  parameter int CW   = 10,
  parameter int MAXD = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hs,
  input  logic       vs,
  input  logic       enable,
  input  logic [1:0] corner,
  input  logic       quarter,
  input  logic       std525,
  input  logic       interlaced,
  input  logic       mixed,
  input  logic [5:0] hoff,
  input  logic [3:0] voff,
  input  logic       frame_on,
  input  logic       frame_narrow,
  input  logic       frame_short,
  input  logic [2:0] hue,
  input  logic       dark_sel,
  input  logic       lvl_en,
  input  logic [3:0] lvl,
  input  logic [2:0] sel_dly,
  output logic       sel,
  output logic [1:0] src,
  output logic [7:0] luma_addr,
  output logic [5:0] chroma_addr,
  output logic [7:0] line_addr,
  output logic [3:0] frame_lvl
);
  localparam int AW = CW + 2;
  localparam logic [1:0] BLACK = 2'd0, INSET = 2'd1, BORDER = 2'd2;
  localparam logic [3:0] LVL_BRIGHT = 4'd12, LVL_DARK = 4'd4;

  logic hs_d, vs_d;
  logic [CW-1:0] pix, line;
  wire hs_rise = hs & ~hs_d;
  wire vs_rise = vs & ~vs_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_d <= 1'b0;
      vs_d <= 1'b0;
      pix  <= '1;
      line <= '1;
    end else begin
      hs_d <= hs;
      vs_d <= vs;
      if (hs_rise)          pix <= '0;
      else if (pix != '1)   pix <= pix + 1'b1;
      if (vs_rise)                    line <= '0;
      else if (hs_rise && line != '1) line <= line + 1'b1;
    end
  end

  logic [AW-1:0] bx, nby, by, x0, y0, bw, bh, iw, ih, fl;
  logic [AW-1:0] ix0, ix1, ox1, iy0, iy1, oy1, px, ly, xrel, yrel;
  logic [3:0] vo;

  always_comb begin
    bx  = corner[0] ? (quarter ? AW'(502) : AW'(448)) : AW'(54);
    if (!corner[1]) nby = std525 ? AW'(41)  : AW'(57);
    else if (quarter) nby = std525 ? AW'(333) : AW'(409);
    else              nby = std525 ? AW'(293) : AW'(365);
    by  = interlaced ? ((nby + 1'b1) >> 1) : nby;
    vo  = mixed ? 4'd0 : voff;
    x0  = bx + AW'({hoff, 2'b00}) - AW'(32);
    y0  = by + AW'({vo, 1'b0}) - AW'(16);
    bw  = frame_narrow ? AW'(4) : AW'(6);
    bh  = frame_short  ? AW'(2) : AW'(3);
    iw  = quarter ? AW'(160) : AW'(212);
    fl  = quarter ? (std525 ? AW'(57) : AW'(66)) : (std525 ? AW'(76) : AW'(88));
    ih  = interlaced ? fl : (fl << 1);
    ix0 = x0 + bw;
    ix1 = ix0 + iw;
    ox1 = ix1 + bw;
    iy0 = y0 + bh;
    iy1 = iy0 + ih;
    oy1 = iy1 + bh;
    px  = AW'(pix);
    ly  = AW'(line);
    xrel = px - ix0;
    yrel = ly - iy0;
  end

  wire in_outer = (px >= x0)  && (px < ox1) && (ly >= y0)  && (ly < oy1);
  wire in_inner = (px >= ix0) && (px < ix1) && (ly >= iy0) && (ly < iy1);
  wire [1:0] region = in_inner ? INSET : (in_outer && frame_on) ? BORDER : BLACK;
  wire win = (region != BLACK);

  logic [MAXD-1:0] win_sh;
  wire tap = (sel_dly == 3'd0) ? win : win_sh[sel_dly - 3'd1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_sh      <= '0;
      sel         <= 1'b0;
      src         <= BLACK;
      luma_addr   <= '0;
      chroma_addr <= '0;
      line_addr   <= '0;
    end else begin
      win_sh <= {win_sh[MAXD-2:0], win};
      sel    <= enable & tap;
      src    <= enable ? region : BLACK;
      if (enable && in_inner) begin
        luma_addr   <= xrel[7:0];
        chroma_addr <= xrel[7:2];
        line_addr   <= yrel[7:0];
      end else begin
        luma_addr   <= '0;
        chroma_addr <= '0;
        line_addr   <= '0;
      end
    end
  end

  wire light = (hue == 3'd3) || (hue >= 3'd5);
  assign frame_lvl = lvl_en ? lvl : ((dark_sel ^ light) ? LVL_BRIGHT : LVL_DARK);

  // R9
  sel_off_chk: assert property (@(posedge clk) disable iff (!rst_n) !enable |=> !sel);
  // R7
  src_code_chk: assert property (@(posedge clk) disable iff (!rst_n) src != 2'b11);
  // R10
  addr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src != INSET) |-> (luma_addr == 8'd0 && chroma_addr == 6'd0 && line_addr == 8'd0));
  // R10
  luma_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src == INSET && $past(src) == INSET && $stable(line_addr)) |-> luma_addr == $past(luma_addr) + 8'd1);
  // R2
  pix_clear_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(hs) |=> pix == '0);
endmodule

// File: tb/sim_pip_overlay_window.sv
module sim_pip_overlay_window;
  localparam int CLK_NS = 10;
  localparam int LINE_LEN = 910;

  logic clk = 0, rst_n = 0, hs = 0, vs = 0, enable = 1;
  logic [1:0] corner = 0;
  logic quarter = 0, std525 = 0, interlaced = 0, mixed = 0;
  logic [5:0] hoff = 6'd8;
  logic [3:0] voff = 4'd8;
  logic frame_on = 1, frame_narrow = 0, frame_short = 0;
  logic [2:0] hue = 0;
  logic dark_sel = 0, lvl_en = 0;
  logic [3:0] lvl = 0;
  logic [2:0] sel_dly = 0;
  logic sel;
  logic [1:0] src;
  logic [7:0] luma_addr, line_addr;
  logic [5:0] chroma_addr;
  logic [3:0] frame_lvl;
  int nchk = 0, nfail = 0;

  always #(CLK_NS/2) clk = ~clk;

  pip_overlay_window u0 (.clk(clk), .rst_n(rst_n), .hs(hs), .vs(vs), .enable(enable),
    .corner(corner), .quarter(quarter), .std525(std525), .interlaced(interlaced),
    .mixed(mixed), .hoff(hoff), .voff(voff), .frame_on(frame_on),
    .frame_narrow(frame_narrow), .frame_short(frame_short), .hue(hue),
    .dark_sel(dark_sel), .lvl_en(lvl_en), .lvl(lvl), .sel_dly(sel_dly),
    .sel(sel), .src(src), .luma_addr(luma_addr), .chroma_addr(chroma_addr),
    .line_addr(line_addr), .frame_lvl(frame_lvl));

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int g_x0();
    int bx = corner[0] ? (quarter ? 502 : 448) : 54;
    return bx + 4 * int'(hoff) - 32;
  endfunction
  function automatic int g_y0();
    int nb, by;
    if (!corner[1]) nb = std525 ? 41 : 57;
    else nb = quarter ? (std525 ? 333 : 409) : (std525 ? 293 : 365);
    by = interlaced ? (nb + 1) / 2 : nb;
    return by + 2 * (mixed ? 0 : int'(voff)) - 16;
  endfunction
  function automatic int g_bw(); return frame_narrow ? 4 : 6; endfunction
  function automatic int g_bh(); return frame_short ? 2 : 3; endfunction
  function automatic int g_w(); return quarter ? 160 : 212; endfunction
  function automatic int g_h();
    int f = quarter ? (std525 ? 57 : 66) : (std525 ? 76 : 88);
    return interlaced ? f : 2 * f;
  endfunction

  function automatic int exp_region(int x, int y);
    int x0 = g_x0(), y0 = g_y0(), bw = g_bw(), bh = g_bh();
    bit inner = x >= x0 + bw && x < x0 + bw + g_w() && y >= y0 + bh && y < y0 + bh + g_h();
    bit outer = x >= x0 && x < x0 + 2 * bw + g_w() && y >= y0 && y < y0 + 2 * bh + g_h();
    if (inner) return 1;
    if (outer && frame_on) return 2;
    return 0;
  endfunction

  function automatic int exp_lvl();
    bit light = (hue == 3) || (hue == 5) || (hue == 6) || (hue == 7);
    if (lvl_en) return int'(lvl);
    return (dark_sel ^ light) ? 12 : 4;
  endfunction

  function automatic int pick_line(int idx);
    int y0 = g_y0(), bh = g_bh(), h = g_h();
    case (idx % 8)
      0: return y0 - 1;
      1: return y0;
      2: return y0 + bh - 1;
      3: return y0 + bh;
      4: return y0 + bh + h - 1;
      5: return y0 + bh + h;
      6: return y0 + 2 * bh + h - 1;
      default: return y0 + 2 * bh + h;
    endcase
  endfunction

  task automatic run_vec(string req, int idx);
    int tl;
    repeat (4) @(negedge clk);
    tl = pick_line(idx);
    hs = 1; vs = 1;
    @(negedge clk); hs = 0; vs = 0;
    for (int i = 0; i < tl; i++) begin
      @(negedge clk); hs = 1;
      @(negedge clk); hs = 0;
    end
    for (int k = 0; k < LINE_LEN; k++) begin
      int r, rs, es;
      @(negedge clk);
      r = enable ? exp_region(k, tl) : 0;
      rs = (k - int'(sel_dly) >= 0) ? exp_region(k - int'(sel_dly), tl) : 0;
      es = (enable && rs != 0) ? 1 : 0;
      chk(req, int'(src), r);
      chk(enable ? "R8" : "R9", int'(sel), es);
      chk("R10", int'(luma_addr), (r == 1) ? k - g_x0() - g_bw() : 0);
      chk("R10", int'(chroma_addr), (r == 1) ? (k - g_x0() - g_bw()) / 4 : 0);
      chk("R10", int'(line_addr), (r == 1) ? tl - g_y0() - g_bh() : 0);
    end
  endtask

  task automatic defaults();
    enable = 1; corner = 0; quarter = 0; std525 = 0; interlaced = 0; mixed = 0;
    hoff = 6'd8; voff = 4'd8; frame_on = 1; frame_narrow = 0; frame_short = 0; sel_dly = 0;
  endtask

  initial begin
    repeat (200000 - 10000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    // R1 reset values
    chk("R1", int'(sel), 0);
    chk("R1", int'(src), 0);
    chk("R1", int'(luma_addr) + int'(chroma_addr) + int'(line_addr), 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1", int'(src), 0);
    chk("R1", int'(sel), 0);

    // R2 coincident vs/hs edge, default placement
    defaults(); run_vec("R2", 1);
    defaults(); run_vec("R2", 3);
    // R3 all corners, both sizes, both standards
    for (int c = 0; c < 8; c++) begin
      defaults(); corner = 2'(c % 4); quarter = c[2]; std525 = c[0];
      run_vec("R3", c);
    end
    // R4 offset extremes and mixed mode
    defaults(); hoff = 6'd0; voff = 4'd0; run_vec("R4", 1);
    defaults(); hoff = 6'd63; voff = 4'd15; corner = 2'd3; quarter = 1; run_vec("R4", 7);
    defaults(); mixed = 1; voff = 4'd15; corner = 2'd2; run_vec("R4", 1);
    // R5 interlaced heights
    defaults(); interlaced = 1; run_vec("R5", 4);
    defaults(); interlaced = 1; std525 = 1; quarter = 1; corner = 2'd2; run_vec("R5", 5);
    defaults(); std525 = 1; run_vec("R5", 4);
    // R6 border variants
    defaults(); frame_on = 0; run_vec("R6", 1);
    defaults(); frame_narrow = 1; frame_short = 1; run_vec("R6", 2);
    defaults(); frame_narrow = 1; run_vec("R6", 6);
    // R8 longest select delay
    defaults(); sel_dly = 3'd7; run_vec("R8", 3);
    // R9 overlay off
    defaults(); enable = 0; run_vec("R9", 3);
    // R7 random configurations
    for (int v = 0; v < 22; v++) begin
      enable = 1; corner = 2'($urandom % 4); quarter = 1'($urandom % 2);
      std525 = 1'($urandom % 2); interlaced = 1'($urandom % 2); mixed = 1'($urandom % 4 == 0);
      hoff = 6'($urandom % 64); voff = 4'($urandom % 16); frame_on = 1'($urandom % 5 != 0);
      frame_narrow = 1'($urandom % 2); frame_short = 1'($urandom % 2); sel_dly = 3'($urandom % 8);
      run_vec("R7", int'($urandom % 8));
    end
    // R11 border brightness
    for (int h = 0; h < 8; h++) begin
      hue = 3'(h); lvl_en = 0; dark_sel = 1'(h % 2); #1;
      chk("R11", int'(frame_lvl), exp_lvl());
    end
    lvl_en = 1;
    for (int v = 0; v < 4; v++) begin
      lvl = 4'($urandom % 16); #1;
      chk("R11", int'(frame_lvl), int'(lvl));
    end
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule